// File: doc/BRIEF.md
# Dual-Wire SPI Byte Transmitter

This block is an SPI master that clocks one 8-bit word per command out to one of three targets. A caller presents a byte, a mode flag and a target number, and pulses `start_i`. In single-wire mode the word goes out on `mosi_o` one bit per serial clock pulse, taking eight pulses. In dual-wire mode the spare select line `aux_o` becomes a second data wire, so each pulse carries two bits and the word takes four pulses.

Every bit period has two halves. First the data and select lines are presented with `sck_o` low. Then `sck_o` is raised while the data is held steady. Each half lasts a number of system clocks taken from `half_i`. During the byte, `miso_i` is sampled into a receive shift register on every rising serial clock edge. The assembled value appears on `rx_o` together with a one-cycle `done_o` pulse. A transmit byte is supplied even when only receive data is wanted. All selects return to their inactive level after every command.

Top module: `duo_spi_tx`

## Requirements
- R1: Out of reset and whenever no byte is in progress, `sck_o`=0, `mosi_o`=0, `aux_o`=1, `sel_top_n_o`=1, `sel_low_n_o`=1, `busy_o`=0 and `done_o`=0. `rx_o` resets to 0x00.
- R2: With `dual_i`=0 the byte is sent in eight serial clock pulses. Pulse k (k=0..7) carries bit 7-k on `mosi_o`, and `aux_o` stays 1 throughout.
- R3: With `dual_i`=1 the byte is sent in four serial clock pulses. Pulse k (k=0..3) carries bit 7-2k on `mosi_o` and bit 6-2k on `aux_o`, so the pairs go out in the order 7:6, 5:4, 3:2, 1:0.
- R4: Each low half and each high half of `sck_o` lasts `half_i` system clocks, and a value of 0 is treated as 1. The data lines change only while `sck_o` is low and stay unchanged through each high half. `half_i` is captured when the start is accepted.
- R5: Selects are active low. Target 2 (`tgt_i`=2'd2) drives `sel_top_n_o` low. Every other target value drives `sel_low_n_o` low. The two are never low together.
- R6: After an accepted start, `busy_o` is 1 from the next cycle until the last high half ends. In the following cycle `busy_o`=0, all selects are inactive, and `done_o` is 1 for exactly that one cycle.
- R7: A start that arrives while `busy_o`=1 is ignored. The byte, mode, target and timing in progress are unaffected, and no extra byte follows.
- R8: `miso_i` is sampled on each rising edge of `sck_o`, with the first sample in the MSB position. When `done_o` rises, `rx_o` shows the 8 samples in single mode, or the 4 samples in bits 3:0 with bits 7:4 zero in dual mode. `rx_o` holds that value until the next `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command request, taken only when idle |
| byte_i | input | 8 | Byte to transmit |
| dual_i | input | 1 | 1 selects two bits per serial clock |
| tgt_i | input | 2 | Target number |
| half_i | input | 8 | System clocks per half serial period (0 acts as 1) |
| miso_i | input | 1 | Serial input data |
| busy_o | output | 1 | Byte in progress |
| done_o | output | 1 | One-cycle pulse after the byte ends |
| rx_o | output | 8 | Received value |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial output data (upper bit of pair in dual mode) |
| aux_o | output | 1 | Spare select line, second data wire in dual mode |
| sel_top_n_o | output | 1 | Active-low select for target 2 |
| sel_low_n_o | output | 1 | Active-low select shared by targets 0, 1 and 3 |

## Verification
The bound checker verifies these properties on every cycle:
- idle line levels;
- that at most one select is low;
- that the data lines stay constant through a high half;
- that selects do not move mid-byte;
- that `done_o` is a single pulse that follows the fall of `busy_o`.

Bit ordering, the dual-mode pairing, the exact half-period lengths, the dropping of a start that arrives mid-byte, and the value assembled on `rx_o` can only be shown by the bench. It compares every cycle against a per-cycle waveform built from the requirements for each scenario.

// File: rtl/duo_spi_pkg.sv
package duo_spi_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_e;

   localparam logic [1:0] TGT_TOP = 2'd2;

endpackage

// File: rtl/duo_spi_timer.sv
module duo_spi_timer #(
   parameter int HALF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic [HALF_W-1:0] half_i,
   input  logic              run_i,
   output logic              tick_o
);
   logic [HALF_W-1:0] lim_q;
   logic [HALF_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == lim_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q <= HALF_W'(1);
         cnt_q <= '0;
      end else if (arm_i) begin
         lim_q <= (half_i == '0) ? HALF_W'(1) : half_i;
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/duo_spi_txshift.sv
module duo_spi_txshift #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic              dual_i,
   input  logic              adv_i,
   output logic              hi_bit_o,
   output logic              lo_bit_o,
   output logic              last_o
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] PULSE_SGL = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] PULSE_DUO = CNT_W'(WORD_W / 2 - 1);

   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  left_q;
   logic              dual_q;

   assign hi_bit_o = sh_q[WORD_W-1];
   assign lo_bit_o = sh_q[WORD_W-2];
   assign last_o   = (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
         dual_q <= 1'b0;
      end else if (load_i) begin
         sh_q   <= data_i;
         left_q <= dual_i ? PULSE_DUO : PULSE_SGL;
         dual_q <= dual_i;
      end else if (adv_i) begin
         sh_q   <= dual_q ? {sh_q[WORD_W-3:0], 2'b00} : {sh_q[WORD_W-2:0], 1'b0};
         left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/duo_spi_rxcap.sv
module duo_spi_rxcap #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              smp_i,
   input  logic              bit_i,
   input  logic              publish_i,
   output logic [WORD_W-1:0] rx_o
);
   logic [WORD_W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         rx_o  <= '0;
      end else begin
         if (clr_i)      acc_q <= '0;
         else if (smp_i) acc_q <= {acc_q[WORD_W-2:0], bit_i};
         if (publish_i)  rx_o  <= acc_q;
      end
   end
endmodule

// File: rtl/duo_spi_tx.sv
module duo_spi_tx #(
   parameter int WORD_W = 8,
   parameter int HALF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WORD_W-1:0] byte_i,
   input  logic              dual_i,
   input  logic [1:0]        tgt_i,
   input  logic [HALF_W-1:0] half_i,
   input  logic              miso_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [WORD_W-1:0] rx_o,
   output logic              sck_o,
   output logic              mosi_o,
   output logic              aux_o,
   output logic              sel_top_n_o,
   output logic              sel_low_n_o
);
   import duo_spi_pkg::*;

   if (WORD_W < 2 || (WORD_W % 2) != 0) begin : g_bad_word
      $error("WORD_W must be even and at least 2");
   end
   if (HALF_W < 1) begin : g_bad_half
      $error("HALF_W must be at least 1");
   end

   phase_e     ph_q;
   logic       dual_q;
   logic [1:0] tgt_q;
   logic       done_q;
   logic       accept, tick, last, hi_bit, lo_bit;
   logic       end_low, end_high, finish;

   assign accept   = start_i && (ph_q == PH_IDLE);
   assign end_low  = tick && (ph_q == PH_LOW);
   assign end_high = tick && (ph_q == PH_HIGH);
   assign finish   = end_high && last;

   duo_spi_timer #(.HALF_W(HALF_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .arm_i(accept), .half_i(half_i),
      .run_i(ph_q != PH_IDLE), .tick_o(tick)
   );

   duo_spi_txshift #(.WORD_W(WORD_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .data_i(byte_i),
      .dual_i(dual_i), .adv_i(end_high && !last),
      .hi_bit_o(hi_bit), .lo_bit_o(lo_bit), .last_o(last)
   );

   duo_spi_rxcap #(.WORD_W(WORD_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr_i(accept), .smp_i(end_low),
      .bit_i(miso_i), .publish_i(finish), .rx_o(rx_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         dual_q <= 1'b0;
         tgt_q  <= 2'd0;
         done_q <= 1'b0;
      end else begin
         done_q <= finish;
         unique case (ph_q)
            PH_IDLE: if (accept) begin
               ph_q   <= PH_LOW;
               dual_q <= dual_i;
               tgt_q  <= tgt_i;
            end
            PH_LOW:  if (end_low) ph_q <= PH_HIGH;
            PH_HIGH: if (end_high) ph_q <= last ? PH_IDLE : PH_LOW;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign busy_o      = (ph_q != PH_IDLE);
   assign done_o      = done_q;
   assign sck_o       = (ph_q == PH_HIGH);
   assign mosi_o      = busy_o && hi_bit;
   assign aux_o       = (busy_o && dual_q) ? lo_bit : 1'b1;
   assign sel_top_n_o = !(busy_o && tgt_q == TGT_TOP);
   assign sel_low_n_o = !(busy_o && tgt_q != TGT_TOP);
endmodule

// File: rtl/duo_spi_chk.sv
module duo_spi_chk (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic done_o,
   input logic sck_o,
   input logic mosi_o,
   input logic aux_o,
   input logic sel_top_n_o,
   input logic sel_low_n_o
);
   AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!sck_o && !mosi_o && aux_o && sel_top_n_o && sel_low_n_o)); // R1
   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({!sel_top_n_o, !sel_low_n_o}) <= 1); // R5
   AST_BUSY_HAS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (!sel_top_n_o || !sel_low_n_o)); // R5
   AST_HIGH_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_o && $past(sck_o)) |-> ($stable(mosi_o) && $stable(aux_o))); // R4
   AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ($stable(sel_top_n_o) && $stable(sel_low_n_o))); // R7
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o))); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6
endmodule

bind duo_spi_tx duo_spi_chk i_chk (
   .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o), .sck_o(sck_o),
   .mosi_o(mosi_o), .aux_o(aux_o), .sel_top_n_o(sel_top_n_o), .sel_low_n_o(sel_low_n_o)
);

// File: tb/test_duo_spi_tx.sv
module test_duo_spi_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] byte_i = 8'h00;
   logic       dual_i = 1'b0;
   logic [1:0] tgt_i = 2'd0;
   logic [7:0] half_i = 8'd1;
   logic       miso_i = 1'b0;
   logic       busy_o, done_o, sck_o, mosi_o, aux_o, sel_top_n_o, sel_low_n_o;
   logic [7:0] rx_o;

   always #2 clk = ~clk;

   duo_spi_tx i_duo_spi_tx (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_i(byte_i), .dual_i(dual_i),
      .tgt_i(tgt_i), .half_i(half_i), .miso_i(miso_i), .busy_o(busy_o), .done_o(done_o),
      .rx_o(rx_o), .sck_o(sck_o), .mosi_o(mosi_o), .aux_o(aux_o),
      .sel_top_n_o(sel_top_n_o), .sel_low_n_o(sel_low_n_o)
   );

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   // expected vector: {rx[7:0], busy, done, sck, mosi, aux, sel_top_n, sel_low_n}
   logic [14:0] q_v[$];
   string       q_t[$];
   logic [7:0]  model_rx = 8'h00;   // rx value after the queued traffic
   logic [7:0]  idle_rx = 8'h00;    // rx value expected while idle
   logic [7:0]  pat = 8'h00;
   int          idx = 0;

   // slave drives the next bit after each rising serial edge
   always @(posedge sck_o) begin
      idx = idx + 1;
      #1 miso_i = (idx < 8) ? pat[7 - idx] : 1'b0;
   end

   function automatic logic [14:0] idle_vec(logic [7:0] rx, logic dn);
      return {rx, 1'b0, dn, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
   endfunction

   always @(negedge clk) begin
      logic [14:0] exp_v;
      string       tag;
      logic [14:0] act_v;
      cycles++;
      if (rst_n) begin
         if (q_v.size() > 0) begin
            exp_v = q_v.pop_front();
            tag   = q_t.pop_front();
            if (exp_v[5]) idle_rx = exp_v[14:7];
         end else begin
            exp_v = idle_vec(idle_rx, 1'b0);
            tag   = "R1";
         end
         act_v = {rx_o, busy_o, done_o, sck_o, mosi_o, aux_o, sel_top_n_o, sel_low_n_o};
         checks++;
         if (act_v !== exp_v) begin
            failures++;
            if (act_v[14:7] !== exp_v[14:7]) tag = "R8";
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act_v, exp_v);
         end
      end
      if (cycles > 20000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic send(input logic [7:0] b, input logic dl, input logic [1:0] tg,
                       input logic [7:0] hf, input logic [7:0] mp, input string tag,
                       input bit poke);
      int h, n;
      logic sa, sb;
      @(posedge clk); #1;
      start_i = 1'b1; byte_i = b; dual_i = dl; tgt_i = tg; half_i = hf;
      pat = mp; idx = 0; miso_i = mp[7];
      h  = (hf == 0) ? 1 : int'(hf);
      n  = dl ? 4 : 8;
      sa = (tg != 2'd2);
      sb = (tg == 2'd2);
      q_v.push_back(idle_vec(model_rx, 1'b0)); q_t.push_back("R1");
      for (int p = 0; p < n; p++) begin
         logic m, a;
         m = dl ? b[7 - 2*p] : b[7 - p];
         a = dl ? b[6 - 2*p] : 1'b1;
         for (int c = 0; c < 2*h; c++) begin
            q_v.push_back({model_rx, 1'b1, 1'b0, (c >= h), m, a, sa, sb});
            q_t.push_back(tag);
         end
      end
      model_rx = dl ? {4'b0000, mp[7:4]} : mp;
      q_v.push_back(idle_vec(model_rx, 1'b1)); q_t.push_back("R6");
      @(posedge clk); #1;
      start_i = 1'b0; byte_i = ~b; half_i = 8'd1;
      if (poke) begin
         // R7: second start mid-byte with different settings must be dropped
         repeat (3) @(posedge clk);
         #1 start_i = 1'b1; byte_i = 8'h5A; dual_i = ~dl; tgt_i = ~tg;
         @(posedge clk); #1 start_i = 1'b0;
      end
      while (q_v.size() > 0) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);           // R1 idle/reset checks
      send(8'hA5, 1'b0, 2'd0, 8'd1, 8'hC3, "R2", 1'b0);
      send(8'h6C, 1'b1, 2'd2, 8'd2, 8'hB7, "R3", 1'b0);
      send(8'h3E, 1'b0, 2'd1, 8'd3, 8'h5D, "R4", 1'b1); // also R7
      send(8'hFF, 1'b1, 2'd3, 8'd0, 8'h9F, "R4", 1'b0);  // half 0 acts as 1
      send(8'h00, 1'b0, 2'd2, 8'd1, 8'hFF, "R5", 1'b0);
      send(8'h81, 1'b1, 2'd0, 8'd1, 8'h20, "R8", 1'b1);
      send(8'h1B, 1'b1, 2'd1, 8'd4, 8'hE1, "R3", 1'b0);
      repeat (5) @(negedge clk);           // rx holds while idle (R8)
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule